// File: doc/BRIEF.md
# Gated ADSR Envelope Generator with Loop Mode

This block is a fully digital attack-decay-sustain-release envelope generator. It runs on a fast system clock and updates its 16-bit unsigned output level only when a sample-rate enable pulse arrives. Each segment is linear. On every sample tick the active segment adds or subtracts a 16-bit step, and the result saturates at that segment's end point: full scale for attack, the sustain level for decay, and zero for release.

The gate input is watched on every system clock. Its edges are latched as pending events and handled at the next sample tick, so the response to a gate edge waits only for the next tick. A gate pulse that is shorter than the tick interval still takes effect. Attack and release always begin from the level the output holds at that moment. The sustain level can be changed while the envelope runs, and the output follows the new value.

A loop mode makes the envelope cycle through attack, decay and release on its own, with no sustain hold. This makes the block usable as a low-frequency oscillator whose shape is set by the three step sizes.

Top module: `adsr_env`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle. After that edge `level` is 0 and `phase` is 0.
- R2: `level` and `phase` change only on a clock edge where `sampleEn` is high.
- R3: A rising gate edge puts the block in attack (`phase` 1) starting from the current level, whatever the phase was. The tick that serves the edge adds `attackStep`. Each later tick adds `attackStep` again, saturating at 0xFFFF.
- R4: The tick on which attack reaches 0xFFFF switches `phase` to decay (2). Decay subtracts `decayStep` on each tick and clamps at `sustainLevel`. The tick that reaches `sustainLevel` switches `phase` to sustain (3).
- R5: In sustain, with loop mode off, each tick loads the present `sustainLevel`, so a changed sustain value appears on the next tick.
- R6: A falling gate edge puts the block in release (`phase` 4) starting from the current level, whatever the phase was. Release subtracts `releaseStep` on each tick. The tick that reaches 0 enters idle (`phase` 0, level 0) when loop mode is off.
- R7: A gate edge seen at any clock edge stays pending until the next `sampleEn` tick, and that tick serves it. A gate pulse of one clock cycle between ticks is not lost.
- R8: If gate edges of both directions are pending at one tick, the gate level present at that tick decides the outcome: high starts attack, low starts release.
- R9: With `loopMode` high, no tick leads to sustain. Decay reaching the sustain level goes to release. Release reaching 0 goes to attack. Idle goes to attack on the next tick.
- R10: A step of 0xFFFF completes a segment in one tick. In loop mode with all three steps at 0xFFFF, the envelope repeats a three-tick cycle: (0xFFFF, decay), (`sustainLevel`, release), (0, attack).
- R11: In idle, with loop mode off and no pending edge, `level` stays 0 across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleEn | input | 1 | One-cycle sample-rate update enable |
| gate | input | 1 | Note gate; its edges start attack or release |
| loopMode | input | 1 | High selects free-running attack, decay, release cycling |
| attackStep | input | 16 | Level added per tick in attack |
| decayStep | input | 16 | Level subtracted per tick in decay |
| releaseStep | input | 16 | Level subtracted per tick in release |
| sustainLevel | input | 16 | Decay floor and sustain hold value |
| level | output | 16 | Envelope output level, unsigned |
| phase | output | 3 | Current segment: 0 idle, 1 attack, 2 decay, 3 sustain, 4 release |

## Verification
Several properties are checked on every cycle:
- Output changes happen only on sample ticks.
- Attack never lowers the level, and release never raises it.
- Decay never ends below the sustain floor.
- Idle always means zero output.
- Loop mode never lands in sustain.
- A gate edge stays pending until a tick serves it.

Other behaviours need the bench's scenarios. These include the exact level after each step and where it saturates, a restart from the middle of another segment, and both edge directions pending at one tick. They also include a sustain change showing up at the output, and the three-tick loop cycle at maximum steps.

// File: rtl/adsr_pkg.sv
package adsr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ATTACK  = 3'd1,
    PH_DECAY   = 3'd2,
    PH_SUSTAIN = 3'd3,
    PH_RELEASE = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_ATTACK  = 3'd2,
    OP_DECAY   = 3'd3,
    OP_RELEASE = 3'd4,
    OP_SUSTAIN = 3'd5
  } segOp_t;

  typedef struct packed {
    logic   en;
    segOp_t op;
  } dpStrobe_t;

endpackage

// File: rtl/adsr_gate_edge.sv
module adsr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic sampleEn,
  output logic pend,
  output logic gateLvl
);

  logic gateQ;
  logic pendQ;
  logic edgeNow;

  assign edgeNow = gate ^ gateQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      gateQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      gateQ <= gate;
      pendQ <= edgeNow | (pendQ & ~sampleEn);
    end
  end

  assign pend    = pendQ;
  assign gateLvl = gateQ;

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (gate != gateQ) |=> pendQ); // R7

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst)
    (pendQ && !sampleEn) |=> pendQ); // R7

endmodule

// File: rtl/adsr_ctrl.sv
module adsr_ctrl
  import adsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleEn,
  input  logic      pend,
  input  logic      gateLvl,
  input  logic      loopMode,
  input  logic      atkTop,
  input  logic      decHit,
  input  logic      relZero,
  output dpStrobe_t stb,
  output phase_t    phaseQ
);

  segOp_t opSel;
  phase_t phaseNxt;

  always_comb begin
    if (pend) begin
      opSel = gateLvl ? OP_ATTACK : OP_RELEASE;
    end else begin
      case (phaseQ)
        PH_IDLE:    opSel = loopMode ? OP_ATTACK : OP_CLEAR;
        PH_ATTACK:  opSel = OP_ATTACK;
        PH_DECAY:   opSel = OP_DECAY;
        PH_SUSTAIN: opSel = loopMode ? OP_RELEASE : OP_SUSTAIN;
        PH_RELEASE: opSel = OP_RELEASE;
        default:    opSel = OP_CLEAR;
      endcase
    end
  end

  always_comb begin
    case (opSel)
      OP_ATTACK:  phaseNxt = atkTop ? PH_DECAY : PH_ATTACK;
      OP_DECAY:   phaseNxt = decHit ? (loopMode ? PH_RELEASE : PH_SUSTAIN) : PH_DECAY;
      OP_RELEASE: phaseNxt = relZero ? (loopMode ? PH_ATTACK : PH_IDLE) : PH_RELEASE;
      OP_SUSTAIN: phaseNxt = PH_SUSTAIN;
      default:    phaseNxt = PH_IDLE;
    endcase
  end

  always_comb begin
    stb.en = sampleEn;
    stb.op = opSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_IDLE;
    end else if (sampleEn) begin
      phaseQ <= phaseNxt;
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (phaseQ inside {PH_IDLE, PH_ATTACK, PH_DECAY, PH_SUSTAIN, PH_RELEASE})); // R4

  AST_LOOP_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sampleEn && loopMode) |=> (phaseQ != PH_SUSTAIN)); // R9

  AST_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(phaseQ)); // R2

endmodule

// File: rtl/adsr_datapath.sv
module adsr_datapath
  import adsr_pkg::*;
#(
  parameter int LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          stb,
  input  logic [LEVEL_W-1:0] attackStep,
  input  logic [LEVEL_W-1:0] decayStep,
  input  logic [LEVEL_W-1:0] releaseStep,
  input  logic [LEVEL_W-1:0] sustainLevel,
  output logic [LEVEL_W-1:0] levelQ,
  output logic               atkTop,
  output logic               decHit,
  output logic               relZero
);

  localparam logic [LEVEL_W-1:0] FULL_SCALE = '1;
  localparam logic [LEVEL_W-1:0] ZERO_LVL   = '0;

  logic [LEVEL_W:0]   atkSum;
  logic [LEVEL_W:0]   decDiff;
  logic [LEVEL_W:0]   relDiff;
  logic [LEVEL_W-1:0] atkNext;
  logic [LEVEL_W-1:0] decNext;
  logic [LEVEL_W-1:0] relNext;

  always_comb begin
    atkSum  = {1'b0, levelQ} + {1'b0, attackStep};
    decDiff = {1'b0, levelQ} - {1'b0, decayStep};
    relDiff = {1'b0, levelQ} - {1'b0, releaseStep};

    atkTop  = atkSum[LEVEL_W] | (atkSum[LEVEL_W-1:0] == FULL_SCALE);
    decHit  = decDiff[LEVEL_W] | (decDiff[LEVEL_W-1:0] <= sustainLevel);
    relZero = relDiff[LEVEL_W] | (relDiff[LEVEL_W-1:0] == ZERO_LVL);

    atkNext = atkTop  ? FULL_SCALE   : atkSum[LEVEL_W-1:0];
    decNext = decHit  ? sustainLevel : decDiff[LEVEL_W-1:0];
    relNext = relZero ? ZERO_LVL     : relDiff[LEVEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= ZERO_LVL;
    end else if (stb.en) begin
      case (stb.op)
        OP_CLEAR:   levelQ <= ZERO_LVL;
        OP_ATTACK:  levelQ <= atkNext;
        OP_DECAY:   levelQ <= decNext;
        OP_RELEASE: levelQ <= relNext;
        OP_SUSTAIN: levelQ <= sustainLevel;
        default:    levelQ <= levelQ;
      endcase
    end
  end

  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !stb.en |=> $stable(levelQ)); // R2

  AST_ATTACK_RISES: assert property (@(posedge clk) disable iff (rst)
    (stb.en && stb.op == OP_ATTACK) |=> (levelQ >= $past(levelQ))); // R3

  AST_DECAY_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (stb.en && stb.op == OP_DECAY) |=> (levelQ >= $past(sustainLevel))); // R4

  AST_RELEASE_FALLS: assert property (@(posedge clk) disable iff (rst)
    (stb.en && stb.op == OP_RELEASE) |=> (levelQ <= $past(levelQ))); // R6

endmodule

// File: rtl/adsr_env.sv
module adsr_env
  import adsr_pkg::*;
#(
  parameter int LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleEn,
  input  logic               gate,
  input  logic               loopMode,
  input  logic [LEVEL_W-1:0] attackStep,
  input  logic [LEVEL_W-1:0] decayStep,
  input  logic [LEVEL_W-1:0] releaseStep,
  input  logic [LEVEL_W-1:0] sustainLevel,
  output logic [LEVEL_W-1:0] level,
  output logic [2:0]         phase
);

  logic      pend;
  logic      gateLvl;
  logic      atkTop;
  logic      decHit;
  logic      relZero;
  dpStrobe_t stb;
  phase_t    phaseQ;

  adsr_gate_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .sampleEn (sampleEn),
    .pend     (pend),
    .gateLvl  (gateLvl)
  );

  adsr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleEn (sampleEn),
    .pend     (pend),
    .gateLvl  (gateLvl),
    .loopMode (loopMode),
    .atkTop   (atkTop),
    .decHit   (decHit),
    .relZero  (relZero),
    .stb      (stb),
    .phaseQ   (phaseQ)
  );

  adsr_datapath #(.LEVEL_W(LEVEL_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .attackStep   (attackStep),
    .decayStep    (decayStep),
    .releaseStep  (releaseStep),
    .sustainLevel (sustainLevel),
    .levelQ       (level),
    .atkTop       (atkTop),
    .decHit       (decHit),
    .relZero      (relZero)
  );

  assign phase = phaseQ;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phaseQ == PH_IDLE) |-> (level == '0)); // R11

  AST_SUSTAIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (sampleEn && phaseQ == PH_SUSTAIN && !pend && !loopMode) |=> (level == $past(sustainLevel))); // R5

endmodule

// File: tb/sim_adsr_env.sv
module sim_adsr_env;

  localparam int P_IDLE = 0, P_ATK = 1, P_DEC = 2, P_SUS = 3, P_REL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleEn = 1'b0;
  logic        gate = 1'b0;
  logic        loopMode = 1'b0;
  logic [15:0] attackStep = 16'h4000;
  logic [15:0] decayStep = 16'h1000;
  logic [15:0] releaseStep = 16'h2000;
  logic [15:0] sustainLevel = 16'h8000;
  logic [15:0] level;
  logic [2:0]  phase;

  int    checks = 0;
  int    failures = 0;
  bit    monOn = 1'b0;
  bit    done = 1'b0;
  logic  tickSeen = 1'b0;
  int    lastLvl = 0;
  int    lastPh = 0;
  int    expLvlQ[$];
  int    expPhQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  adsr_env u0 (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .gate(gate), .loopMode(loopMode),
    .attackStep(attackStep), .decayStep(decayStep), .releaseStep(releaseStep),
    .sustainLevel(sustainLevel), .level(level), .phase(phase)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int lvl, input int ph, input string tag);
    @(negedge clk);
    expLvlQ.push_back(lvl);
    expPhQ.push_back(ph);
    tagQ.push_back(tag);
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setGate(input logic v);
    @(negedge clk);
    gate = v;
    idle(2);
  endtask

  always @(posedge clk) tickSeen <= sampleEn && !rst;

  // Monitor: scoreboard pop on tick cycles, hold check otherwise
  always @(negedge clk) begin
    if (monOn) begin
      if (tickSeen) begin
        if (expLvlQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected tick", 0, 0);
        end else begin
          int el;
          int ep;
          string t;
          el = expLvlQ.pop_front();
          ep = expPhQ.pop_front();
          t  = tagQ.pop_front();
          chk(level == el[15:0], t, "level", int'(level), el);
          chk(phase == ep[2:0], t, "phase", int'(phase), ep);
          lastLvl = el;
          lastPh  = ep;
        end
      end else begin
        chk(level == lastLvl[15:0] && phase == lastPh[2:0], "R2", "hold between ticks",
            int'(level), lastLvl);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    idle(4);
    chk(level == 16'h0, "R1", "reset level", int'(level), 0);
    chk(phase == 3'd0, "R1", "reset phase", int'(phase), 0);
    rst = 1'b0;
    monOn = 1'b1;

    // R11: idle stays at zero
    tick(0, P_IDLE, "R11");
    tick(0, P_IDLE, "R11");

    // R3 attack from zero, saturating into decay (R4)
    setGate(1'b1);
    tick('h4000, P_ATK, "R3");
    tick('h8000, P_ATK, "R3");
    tick('hC000, P_ATK, "R3");
    tick('hFFFF, P_DEC, "R4");
    v = 'hFFFF;
    for (int k = 0; k < 7; k++) begin
      v -= 'h1000;
      tick(v, P_DEC, "R4");
    end
    tick('h8000, P_SUS, "R4");
    tick('h8000, P_SUS, "R5");

    // R5 sustain follows a new value
    @(negedge clk);
    sustainLevel = 16'h6000;
    tick('h6000, P_SUS, "R5");

    // R6 release to idle
    setGate(1'b0);
    tick('h4000, P_REL, "R6");
    tick('h2000, P_REL, "R6");
    tick('h0000, P_IDLE, "R6");

    // Restarts from the current level
    setGate(1'b1);
    tick('h4000, P_ATK, "R3");
    setGate(1'b0);
    tick('h2000, P_REL, "R6");
    setGate(1'b1);
    tick('h6000, P_ATK, "R3");
    setGate(1'b0);
    tick('h4000, P_REL, "R6");
    tick('h2000, P_REL, "R6");
    tick('h0000, P_IDLE, "R6");

    // R7/R8: one-cycle high pulse from idle resolves to low gate
    @(negedge clk); gate = 1'b1;
    @(negedge clk); gate = 1'b0;
    idle(3);
    tick(0, P_IDLE, "R8");

    // Reach sustain at 0x6000, then low pulse resolves to high gate
    setGate(1'b1);
    tick('h4000, P_ATK, "R3");
    tick('h8000, P_ATK, "R3");
    tick('hC000, P_ATK, "R3");
    tick('hFFFF, P_DEC, "R4");
    v = 'hFFFF;
    while (v - 'h1000 > 'h6000) begin
      v -= 'h1000;
      tick(v, P_DEC, "R4");
    end
    tick('h6000, P_SUS, "R4");
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    idle(3);
    tick('hA000, P_ATK, "R8");
    tick('hE000, P_ATK, "R3");
    tick('hFFFF, P_DEC, "R4");

    // R6 release from decay down to zero
    setGate(1'b0);
    v = 'hFFFF;
    while (v > 'h2000) begin
      v -= 'h2000;
      tick(v, P_REL, "R6");
    end
    tick(0, P_IDLE, "R6");

    // R7: edge on the same cycle as a tick is served at the following tick
    @(negedge clk);
    gate = 1'b1;
    expLvlQ.push_back(0); expPhQ.push_back(P_IDLE); tagQ.push_back("R7");
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
    idle(2);
    tick('h4000, P_ATK, "R7");
    setGate(1'b0);
    tick('h2000, P_REL, "R6");
    tick(0, P_IDLE, "R6");

    // R9/R10 loop mode with maximal steps
    @(negedge clk);
    attackStep = 16'hFFFF;
    decayStep = 16'hFFFF;
    releaseStep = 16'hFFFF;
    sustainLevel = 16'h8000;
    loopMode = 1'b1;
    for (int p = 0; p < 3; p++) begin
      tick('hFFFF, P_DEC, "R10");
      tick('h8000, P_REL, "R9");
      tick('h0000, P_ATK, "R10");
    end

    idle(3);
    chk(expLvlQ.size() == 0, "R2", "scoreboard drained", expLvlQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule